// File: doc/BRIEF.md
# Hitless Reference Switch Sequencer

This block is the digital control sequencer for a clock-reference switchover in a phase-locked loop. After reset it waits in an unarmed state until the loop reports a qualified lock, meaning a run of consecutive in-window phase comparisons. It then arms itself. Once armed, a loss-of-lock event starts a recovery. The sequencer first turns the phase detector off and forces the narrow loop bandwidth. If the phase build-out option is strapped on, it then asks the build-out unit to realign the feedback edge. After that it turns the phase detector back on and waits for a fresh qualified lock. A fixed settle timer follows. When the timer expires, the loop returns to wide bandwidth and the sequencer arms again.

The block has no analog parts. The loop filter resistor and the oscillator are driven only through the phase-detector enable and the narrow-bandwidth select. The settle window is given in nanoseconds and the clock period in picoseconds. The counter limit is rounded up, so the window is never shorter than asked.

Top module: `hitless_switch_seq`

## Requirements
- R1: After reset the block is unarmed (`armed`=0). It arms when `lock_ok` has been sampled high on QUAL_CYCLES consecutive rising edges (8 by default), and `armed` goes high in the cycle after the last of those edges.
- R2: When `lol_event` is sampled high while `armed`=1, the next cycle shows `pd_en`=0, `nbw_sel`=1 and `armed`=0. This first step is the hold cycle, and it lasts exactly one cycle.
- R3: A `lol_event` that arrives before the block has armed has no effect. Outputs stay at their idle values and the arming count goes on.
- R4: With `pbo_option`=1, the cycle after the hold cycle shows `pbo_req`=1 and `pd_en`=0. Both stay that way until `pbo_done` is sampled high. The next cycle then shows `pbo_req`=0 and `pd_en`=1.
- R5: With `pbo_option`=0, `pbo_req` never rises, and `pd_en` returns to 1 in the cycle after the hold cycle.
- R6: After `pd_en` returns, the settle timer starts only once `lock_ok` has been sampled high on QUAL_CYCLES consecutive edges. Any low sample restarts that count, and `nbw_sel` stays high throughout.
- R7: The settle window lasts ceil(SETTLE_NS*1000/CLK_PERIOD_PS) cycles (18 by default). After it, `nbw_sel` returns to `nbw_strap` and `armed`=1.
- R8: While `nbw_strap`=1, `nbw_sel` is 1 in every cycle.
- R9: A `lol_event` during a running recovery is ignored and does not restart it. `pbo_done` outside the build-out step has no effect.
- R10: A synchronous active-high `rst` leaves the block unarmed with `pd_en`=1, `pbo_req`=0 and `nbw_sel`=`nbw_strap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_ok | input | 1 | Per-cycle indication that the compared phases lie within the lock window |
| lol_event | input | 1 | Loss-of-lock indication |
| pbo_done | input | 1 | Phase build-out unit finished realignment |
| pbo_option | input | 1 | Strap: phase build-out step present |
| nbw_strap | input | 1 | Strap: loop permanently in narrow bandwidth |
| pd_en | output | 1 | Phase detector enable |
| nbw_sel | output | 1 | Narrow loop bandwidth select |
| pbo_req | output | 1 | Request to the phase build-out unit |
| armed | output | 1 | Sequencer armed and waiting for loss of lock |

## Verification
The hardest case to reach from the ports is a lock run that fails partway through the re-lock step. The sequence has to be interrupted exactly there, with a stray `lol_event` arriving at the same time, so that a wrong restart of either the qualification count or the whole recovery would show up. The directed part builds this case on purpose: five good samples, one miss, a burst of loss-of-lock, then a clean run. It then counts the settle cycles until the block arms. The random part keeps `lock_ok` mostly high but sometimes drops it. It also pulses loss-of-lock and build-out done at low rates, so recoveries overlap with noise in every step.

// File: rtl/hss_pkg.sv
package hss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_HOLD   = 3'd2,
        ST_BUILD  = 3'd3,
        ST_RELOCK = 3'd4,
        ST_SETTLE = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/hss_lock_qual.sv
// Counts consecutive in-window samples; hit fires on the QUAL-th one.
module hss_lock_qual #(
    parameter int QUAL = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    output logic hit
);
    localparam int CW = (QUAL > 1) ? $clog2(QUAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = !clear && sample && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear || !sample || hit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hss_settle_timer.sv
// Runs while run is high; done fires in the LEN-th consecutive run cycle.
module hss_settle_timer #(
    parameter int LEN = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == LAST);
        cnt_d = (run && !done) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hitless_switch_seq.sv
module hitless_switch_seq
    import hss_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int SETTLE_NS     = 175,
    parameter int QUAL_CYCLES   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_ok,
    input  logic lol_event,
    input  logic pbo_done,
    input  logic pbo_option,
    input  logic nbw_strap,
    output logic pd_en,
    output logic nbw_sel,
    output logic pbo_req,
    output logic armed
);
    localparam int SETTLE_CYC =
        (SETTLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int SETTLE_LEN = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;

    seq_regs_t r_d, r_q;
    logic      qual_clear;
    logic      qual_hit;
    logic      timer_run;
    logic      timer_done;

    hss_lock_qual #(.QUAL(QUAL_CYCLES)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .clear  (qual_clear),
        .sample (lock_ok),
        .hit    (qual_hit)
    );

    hss_settle_timer #(.LEN(SETTLE_LEN)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (timer_run),
        .done (timer_done)
    );

    always_comb begin
        r_d        = r_q;
        qual_clear = 1'b1;
        timer_run  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                qual_clear = 1'b0;
                if (qual_hit) r_d.state = ST_ARMED;
            end
            ST_ARMED: begin
                if (lol_event) r_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                r_d.state = pbo_option ? ST_BUILD : ST_RELOCK;
            end
            ST_BUILD: begin
                if (pbo_done) r_d.state = ST_RELOCK;
            end
            ST_RELOCK: begin
                qual_clear = 1'b0;
                if (qual_hit) r_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                timer_run = 1'b1;
                if (timer_done) r_d.state = ST_ARMED;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q.state <= ST_IDLE;
        else     r_q       <= r_d;
    end

    always_comb begin
        pd_en   = !(r_q.state inside {ST_HOLD, ST_BUILD});
        pbo_req = (r_q.state == ST_BUILD);
        armed   = (r_q.state == ST_ARMED);
        nbw_sel = nbw_strap ||
                  (r_q.state inside {ST_HOLD, ST_BUILD, ST_RELOCK, ST_SETTLE});
    end
endmodule

// File: rtl/hss_checker.sv
module hss_checker (
    input logic clk,
    input logic rst,
    input logic lol_event,
    input logic pbo_done,
    input logic nbw_strap,
    input logic pd_en,
    input logic nbw_sel,
    input logic pbo_req,
    input logic armed
);
    a_r2_trigger: assert property (@(posedge clk) disable iff (rst)
        (armed && lol_event) |=> (!pd_en && nbw_sel && !armed));

    a_r4_pd_off_in_build: assert property (@(posedge clk) disable iff (rst)
        pbo_req |-> !pd_en);

    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        (pbo_req && !pbo_done) |=> pbo_req);

    a_r8_strap_narrow: assert property (@(posedge clk) disable iff (rst)
        nbw_strap |-> nbw_sel);

    a_r7_armed_wide: assert property (@(posedge clk) disable iff (rst)
        armed |-> (pd_en && (nbw_sel == nbw_strap) && !pbo_req));

    a_r10_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pd_en && !pbo_req && !armed));
endmodule

bind hitless_switch_seq hss_checker u_chk (.*);

// File: tb/hitless_switch_seq_test.sv
module hitless_switch_seq_test;
    localparam int CLK_PERIOD_PS = 10000;
    localparam int SETTLE_NS     = 175;
    localparam int QUAL          = 8;
    localparam int TCYC = (SETTLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_ok = 1'b0, lol_event = 1'b0, pbo_done = 1'b0;
    logic pbo_option = 1'b0, nbw_strap = 1'b0;
    logic pd_en, nbw_sel, pbo_req, armed;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // model: 0 idle, 1 armed, 2 hold, 3 build, 4 relock, 5 settle
    int ms = 0;
    int mq = 0;
    int mt = 0;

    always #5 clk = ~clk;

    hitless_switch_seq #(
        .CLK_PERIOD_PS(CLK_PERIOD_PS), .SETTLE_NS(SETTLE_NS), .QUAL_CYCLES(QUAL)
    ) uut (
        .clk(clk), .rst(rst), .lock_ok(lock_ok), .lol_event(lol_event),
        .pbo_done(pbo_done), .pbo_option(pbo_option), .nbw_strap(nbw_strap),
        .pd_en(pd_en), .nbw_sel(nbw_sel), .pbo_req(pbo_req), .armed(armed)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_pd(input int s);   return !(s == 2 || s == 3); endfunction
    function automatic bit exp_pbo(input int s);  return s == 3; endfunction
    function automatic bit exp_arm(input int s);  return s == 1; endfunction
    function automatic bit exp_nbw(input int s, input bit strap);
        return strap || (s >= 2);
    endfunction

    task automatic model_step();
        if (rst) begin
            ms = 0; mq = 0; mt = 0;
        end else begin
            case (ms)
                0, 4: begin
                    if (lock_ok) begin
                        if (mq == QUAL - 1) begin
                            mq = 0; mt = 0;
                            ms = (ms == 0) ? 1 : 5;
                        end else mq++;
                    end else mq = 0;
                end
                1: if (lol_event) ms = 2;
                2: begin ms = pbo_option ? 3 : 4; mq = 0; end
                3: begin mq = 0; if (pbo_done) ms = 4; end
                5: begin
                    if (mt == TCYC - 1) begin ms = 1; mt = 0; end
                    else mt++;
                end
                default: ms = 0;
            endcase
        end
    endtask

    task automatic compare_all();
        check(pd_en == exp_pd(ms), "R3/R5 pd_en", pd_en, exp_pd(ms));
        check(pbo_req == exp_pbo(ms), "R4 pbo_req", pbo_req, exp_pbo(ms));
        check(armed == exp_arm(ms), "R1 armed", armed, exp_arm(ms));
        check(nbw_sel == exp_nbw(ms, nbw_strap), "R8 nbw_sel", nbw_sel,
              exp_nbw(ms, nbw_strap));
    endtask

    // called at a falling edge; drives, steps one rising edge, compares
    task automatic cyc(input bit r, input bit lk, input bit lol, input bit pd,
                       input bit po, input bit ns);
        rst = r; lock_ok = lk; lol_event = lol; pbo_done = pd;
        pbo_option = po; nbw_strap = ns;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // R10: reset state
        check(pd_en && !pbo_req && !armed && !nbw_sel, "R10 reset outputs",
              {pd_en, pbo_req, armed, nbw_sel}, 4'b1000);

        // R3: loss of lock while unarmed is ignored; R1 arming after 8 samples
        for (int i = 0; i < QUAL - 1; i++) cyc(0, 1, 1, 0, 0, 0);
        check(!armed && pd_en, "R3 unarmed lol ignored", armed, 0);
        cyc(0, 1, 0, 0, 0, 0);
        check(armed, "R1 armed after qualified lock", armed, 1);

        // R2 trigger, R5 no build-out
        cyc(0, 0, 1, 0, 0, 0);
        check(!pd_en && nbw_sel && !armed, "R2 hold step", pd_en, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(pd_en && !pbo_req, "R5 pd back without build-out", pd_en, 1);

        // R6 broken run, R9 lol during recovery ignored
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0);
        check(nbw_sel && pd_en && !armed, "R9 lol in relock ignored", nbw_sel, 1);
        for (int i = 0; i < QUAL - 2; i++) cyc(0, 1, 0, 0, 0, 0);
        check(nbw_sel && !armed, "R6 still qualifying", nbw_sel, 1);
        cyc(0, 1, 0, 0, 0, 0); // qualified: settle starts
        n = 0;
        while (!armed && n < 100) begin cyc(0, 0, 1, 0, 0, 0); n++; end
        check(n == TCYC, "R7 settle length", n, TCYC);
        check(!nbw_sel, "R7 wide bandwidth restored", nbw_sel, 0);

        // R4 build-out path, R9 pbo_done while armed ignored
        cyc(0, 1, 0, 1, 1, 0);
        check(armed, "R9 pbo_done ignored when armed", armed, 1);
        cyc(0, 1, 1, 0, 1, 0);
        cyc(0, 1, 0, 0, 1, 0);
        check(pbo_req && !pd_en, "R4 build-out requested", pbo_req, 1);
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 0);
        check(pbo_req && !pd_en, "R4 request held", pbo_req, 1);
        cyc(0, 1, 0, 1, 1, 0);
        check(!pbo_req && pd_en, "R4 released on done", pbo_req, 0);

        // R8 narrow strap
        for (int i = 0; i < 40; i++) cyc(0, 1, (i == 12), 0, 0, 1);
        check(nbw_sel, "R8 strap keeps narrow", nbw_sel, 1);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit r  = ($urandom_range(0, 499) == 0);
            bit lk = ($urandom_range(0, 99) < 88);
            bit lo = ($urandom_range(0, 99) < 4);
            bit pd = ($urandom_range(0, 99) < 25);
            bit po = ((i / 700) % 2) == 1;
            bit ns = ((i / 1500) % 4) == 3;
            cyc(r, lk, lo, pd, po, ns);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule